// File: doc/BRIEF.md
# Pipelined Memory Read Streamer

This block copies a run of consecutive words out of a memory-mapped slave and presents them, in address order, on a ready/valid stream. A command gives a starting word address and a word count. The block then issues single-word read requests back to back. It does not wait for earlier data before issuing the next request, so several reads can be in flight together.

Data coming back from the slave is captured into a small internal FIFO, and the stream output drains that FIFO. A credit counter tracks the reads that have been accepted but have not yet returned. A request is issued only if those in-flight reads plus the words already held in the FIFO leave room for one more word. As a result, a returned word always has a slot, even when the stream consumer stalls for a long time. When the last word has arrived and nothing is in flight, a one-cycle completion pulse is raised.

Top module: `rd_stream_master`

## Requirements
- R1: While `rst_ni` is low, `mm_read_o`, `st_valid_o` and `done_o` are 0 and `cmd_ready_o` is 1.
- R2: A command is taken on a rising edge where `cmd_valid_i` and `cmd_ready_o` are both 1. `cmd_ready_o` stays 0 from that edge until the edge that ends the `done_o` cycle, and a command offered in that window has no effect on the addresses issued.
- R3: Every read drives `mm_byteenable_o` all ones. The k-th accepted read (k from 0) carries address `cmd_addr_i + k`, modulo 2^ADDR_W. Exactly `cmd_len_i` reads are accepted per command.
- R4: While `mm_read_o` is 1 and `mm_waitrequest_i` is 1, the request stays asserted on the next cycle with the same address. A read counts as accepted on an edge where `mm_read_o` is 1 and `mm_waitrequest_i` is 0.
- R5: Reads accepted but not yet returned, plus words held in the FIFO, never exceed FIFO_DEPTH. With the stream stalled, exactly FIFO_DEPTH reads are accepted and then `mm_read_o` stays 0.
- R6: A word is captured on every edge where `mm_readdatavalid_i` is 1, whatever the value of `mm_waitrequest_i`. Captured words leave on the stream in arrival order. `st_valid_o` is 1 exactly when at least one captured word has not yet been popped.
- R7: A word is popped on an edge where `st_valid_o` and `st_ready_i` are both 1. While `st_valid_o` is 1 and `st_ready_i` is 0, `st_valid_o` and `st_data_o` hold on the next cycle.
- R8: `done_o` is 1 for exactly one cycle: the first cycle in which all `cmd_len_i` words have been captured and no read is in flight. A zero-length command raises `done_o` in the cycle after it is taken, and no read is issued for it.
- R9: A new read can be accepted while earlier reads are still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle; command can be taken |
| cmd_addr_i | input | ADDR_W | Starting word address |
| cmd_len_i | input | LEN_W | Number of words to read |
| mm_read_o | output | 1 | Read request |
| mm_address_o | output | ADDR_W | Read word address |
| mm_byteenable_o | output | DATA_W/8 | Byte enables, always all ones |
| mm_waitrequest_i | input | 1 | Slave stalls the request |
| mm_readdata_i | input | DATA_W | Returned read data |
| mm_readdatavalid_i | input | 1 | Returned data valid |
| st_valid_o | output | 1 | Stream word available |
| st_ready_i | input | 1 | Stream consumer accepts |
| st_data_o | output | DATA_W | Stream word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The request and its address are combinational from the block's state, so they are due in the cycle that follows the accepting edge of a command or a read, with no extra delay. A word that returns on an edge shows up on `st_valid_o`/`st_data_o` in the next cycle. `done_o` rises in the cycle after the edge that captures the last word, or after the edge that takes a zero-length command. The bench drives all inputs on the falling edge and samples 1 ns later. Each sample is compared with a model that has already applied every handshake from the previous rising edge, so every expected value is checked in the exact cycle it is due.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rsm_state_e;
endpackage

// File: rtl/rsm_fifo.sv
module rsm_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rsm_credit.sv
module rsm_credit #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rsm_issue.sv
module rsm_issue
  import rsm_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  output logic              cmd_ready_o,
  input  logic              credit_ok_i,
  input  logic              accept_i,
  input  logic              rdv_i,
  input  logic              out_zero_i,
  output logic              read_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  rsm_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  issue_left_q, recv_left_q;
  logic              run;

  assign run         = (state_q == ST_RUN);
  assign cmd_ready_o = (state_q == ST_IDLE);
  // once raised, credit cannot shrink until accept, so the request holds
  assign read_o      = run && (issue_left_q != '0) && credit_ok_i;
  assign addr_o      = addr_q;
  assign done_o      = run && (recv_left_q == '0) && out_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      issue_left_q <= '0;
      recv_left_q  <= '0;
    end else if (!run) begin
      if (cmd_valid_i) begin
        state_q      <= ST_RUN;
        addr_q       <= cmd_addr_i;
        issue_left_q <= cmd_len_i;
        recv_left_q  <= cmd_len_i;
      end
    end else begin
      if (accept_i) begin
        addr_q       <= addr_q + 1'b1;
        issue_left_q <= issue_left_q - 1'b1;
      end
      if (rdv_i && (recv_left_q != '0)) recv_left_q <= recv_left_q - 1'b1;
      if (done_o) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/rd_stream_master.sv
module rd_stream_master #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 8,
  localparam int BE_W      = DATA_W / 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  output logic              mm_read_o,
  output logic [ADDR_W-1:0] mm_address_o,
  output logic [BE_W-1:0]   mm_byteenable_o,
  input  logic              mm_waitrequest_i,
  input  logic [DATA_W-1:0] mm_readdata_i,
  input  logic              mm_readdatavalid_i,
  output logic              st_valid_o,
  input  logic              st_ready_i,
  output logic [DATA_W-1:0] st_data_o,
  output logic              done_o
);
  logic [CNT_W-1:0] out_cnt, fifo_cnt;
  logic             accept, pop, credit_ok;

  assign accept          = mm_read_o && !mm_waitrequest_i;
  assign st_valid_o      = (fifo_cnt != '0);
  assign pop             = st_valid_o && st_ready_i;
  assign mm_byteenable_o = '1;
  assign credit_ok       = ({1'b0, out_cnt} + {1'b0, fifo_cnt}) < (CNT_W + 1)'(FIFO_DEPTH);

  rsm_issue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_len_i   (cmd_len_i),
    .cmd_ready_o (cmd_ready_o),
    .credit_ok_i (credit_ok),
    .accept_i    (accept),
    .rdv_i       (mm_readdatavalid_i),
    .out_zero_i  (out_cnt == '0),
    .read_o      (mm_read_o),
    .addr_o      (mm_address_o),
    .done_o      (done_o)
  );

  rsm_credit #(.CNT_W(CNT_W)) u_credit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (accept),
    .dec_i  (mm_readdatavalid_i),
    .cnt_o  (out_cnt)
  );

  rsm_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (mm_readdatavalid_i),
    .wdata_i (mm_readdata_i),
    .pop_i   (pop),
    .rdata_o (st_data_o),
    .count_o (fifo_cnt)
  );
endmodule

// File: rtl/rsm_checker.sv
module rsm_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ready_i,
  input logic              mm_read_i,
  input logic [ADDR_W-1:0] mm_address_i,
  input logic              mm_waitrequest_i,
  input logic              st_valid_i,
  input logic              st_ready_i,
  input logic [DATA_W-1:0] st_data_i,
  input logic              done_i,
  input logic [CNT_W-1:0]  out_cnt_i,
  input logic [CNT_W-1:0]  fifo_cnt_i
);
  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_read_i && mm_waitrequest_i |=> mm_read_i && $stable(mm_address_i));

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, out_cnt_i} + {1'b0, fifo_cnt_i}) <= (CNT_W + 1)'(DEPTH));

  a_r5_full_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt_i == CNT_W'(DEPTH)) |-> !mm_read_i);

  a_r7_stream_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && !st_ready_i |=> st_valid_i && $stable(st_data_i));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r2_busy_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !cmd_ready_i);
endmodule

bind rd_stream_master rsm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_rsm_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cmd_ready_i      (cmd_ready_o),
  .mm_read_i        (mm_read_o),
  .mm_address_i     (mm_address_o),
  .mm_waitrequest_i (mm_waitrequest_i),
  .st_valid_i       (st_valid_o),
  .st_ready_i       (st_ready_i),
  .st_data_i        (st_data_o),
  .done_i           (done_o),
  .out_cnt_i        (out_cnt),
  .fifo_cnt_i       (fifo_cnt)
);

// File: tb/rd_stream_master_bench.sv
`timescale 1ns/1ps
module rd_stream_master_bench;
  localparam int AW = 24, DW = 16, LW = 16, DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic          mm_read, mm_wait = 1'b0, mm_rdv = 1'b0;
  logic [AW-1:0] mm_addr;
  logic [1:0]    mm_be;
  logic [DW-1:0] mm_rdata = '0;
  logic          st_valid, st_ready = 1'b0, done;
  logic [DW-1:0] st_data;

  always #2.5 clk = ~clk;

  rd_stream_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .FIFO_DEPTH(DEPTH)) u_rd_stream_master (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len),
    .mm_read_o(mm_read), .mm_address_o(mm_addr), .mm_byteenable_o(mm_be),
    .mm_waitrequest_i(mm_wait), .mm_readdata_i(mm_rdata), .mm_readdatavalid_i(mm_rdv),
    .st_valid_o(st_valid), .st_ready_i(st_ready), .st_data_o(st_data), .done_o(done)
  );

  int tests = 0, fails = 0;
  int rdy_pct = 100, wait_pct = 0, max_lat = 1;
  int unsigned cyc = 0;
  int unsigned due_q[$];
  logic [AW-1:0] aq[$];
  bit busy_tb = 0, saw_pipe = 0;
  logic [AW-1:0] base = '0;
  int len_tb = 0, acc = 0, ret = 0, pop = 0;
  bit prev_stall = 0, prev_hold = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_data = '0;

  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
    return a[15:0] ^ {a[23:16], a[7:0]} ^ 16'hC35A;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // slave model and cycle monitor
  always begin
    @(negedge clk);
    cyc++;
    mm_wait  = ($urandom % 100) < wait_pct;
    st_ready = ($urandom % 100) < rdy_pct;
    if (due_q.size() > 0 && due_q[0] <= cyc) begin
      mm_rdv   = 1'b1;
      mm_rdata = mem_word(aq[0]);
      void'(due_q.pop_front());
      void'(aq.pop_front());
    end else begin
      mm_rdv   = 1'b0;
      mm_rdata = DW'($urandom);
    end
    #1;
    if (rst_n) begin
      bit exp_done;
      exp_done = busy_tb && (ret == len_tb);
      chk(cmd_ready == !busy_tb, "R2 cmd_ready", 32'(cmd_ready), 32'(!busy_tb));
      chk(done == exp_done, "R8 done", 32'(done), 32'(exp_done));
      chk(st_valid == (ret > pop), "R6 st_valid", 32'(st_valid), 32'(ret > pop));
      if (prev_hold)
        chk(st_valid && st_data == prev_data, "R7 hold", 32'(st_data), 32'(prev_data));
      if (prev_stall)
        chk(mm_read && mm_addr == prev_addr, "R4 hold", 32'(mm_addr), 32'(prev_addr));
      if (mm_read)
        chk(mm_be == 2'b11 && mm_addr == AW'(base + AW'(acc)) && acc < len_tb,
            "R3 request", 32'(mm_addr), 32'(AW'(base + AW'(acc))));
      prev_stall = mm_read && mm_wait;
      prev_addr  = mm_addr;
      if (mm_read && !mm_wait) begin
        int unsigned d;
        if (acc > ret) saw_pipe = 1;
        d = cyc + 1 + ($urandom % max_lat);
        if (due_q.size() > 0 && d <= due_q[$]) d = due_q[$] + 1;
        due_q.push_back(d);
        aq.push_back(mm_addr);
        acc++;
      end
      if (mm_rdv) ret++;
      if (st_valid && st_ready) begin
        chk(st_data == mem_word(AW'(base + AW'(pop))), "R6 data order",
            32'(st_data), 32'(mem_word(AW'(base + AW'(pop)))));
        pop++;
      end
      prev_hold = st_valid && !st_ready;
      prev_data = st_data;
      chk(acc - pop <= DEPTH, "R5 credit", 32'(acc - pop), DEPTH);
      if (exp_done) busy_tb = 0;
      if (cmd_valid && cmd_ready) begin
        base = cmd_addr; len_tb = int'(cmd_len);
        acc = 0; ret = 0; pop = 0; busy_tb = 1;
      end
    end
  end

  task automatic start_cmd(logic [AW-1:0] a, logic [LW-1:0] l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_len = l;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_end();
    while (busy_tb || pop != len_tb) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(acc == len_tb, "R3 read count", 32'(acc), 32'(len_tb));
  endtask

  // {addr, len, ready%, waitrequest%, max latency}
  localparam logic [63:0] VEC [6] = '{
    {24'h000000, 16'd1,  8'd100, 8'd0,  8'd1},
    {24'h000010, 16'd16, 8'd100, 8'd0,  8'd1},
    {24'h001000, 16'd33, 8'd50,  8'd40, 8'd6},
    {24'hFFFFF8, 16'd20, 8'd80,  8'd70, 8'd3},
    {24'h0ABCDE, 16'd40, 8'd20,  8'd20, 8'd10},
    {24'h123456, 16'd25, 8'd100, 8'd50, 8'd12}
  };

  initial begin
    #1;
    chk(!mm_read && !st_valid && !done && cmd_ready, "R1 reset",
        {28'd0, mm_read, st_valid, done, cmd_ready}, 32'h1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      rdy_pct = int'(VEC[i][23:16]); wait_pct = int'(VEC[i][15:8]); max_lat = int'(VEC[i][7:0]);
      start_cmd(VEC[i][63:40], VEC[i][39:24]);
      wait_end();
    end
    chk(saw_pipe, "R9 pipelined issue", 32'(saw_pipe), 1);

    // R8: zero length
    rdy_pct = 100; wait_pct = 0; max_lat = 2;
    start_cmd(24'h000500, 16'd0);
    wait_end();
    chk(acc == 0, "R8 zero length reads", 32'(acc), 0);

    // R5: stalled stream caps issue at FIFO depth
    rdy_pct = 0; wait_pct = 0; max_lat = 2;
    start_cmd(24'h002000, 16'd20);
    repeat (40) @(negedge clk);
    #1;
    chk(acc == DEPTH, "R5 stalled accept count", 32'(acc), DEPTH);
    chk(!mm_read, "R5 stalled no request", 32'(mm_read), 0);
    rdy_pct = 100;
    wait_end();

    // R2: command during busy is ignored
    rdy_pct = 30; wait_pct = 30; max_lat = 4;
    start_cmd(24'h003000, 16'd12);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 24'h999999; cmd_len = 16'd3;
    repeat (5) @(negedge clk);
    cmd_valid = 1'b0;
    wait_end();
    chk(base == 24'h003000 && len_tb == 12, "R2 ignored while busy", 32'(base), 32'h3000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule